// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This unit runs one packed integer operation per cycle on a pair of 128-bit operand vectors. The vectors are split into independent lanes of 8, 16, 32 or 64 bits. Each lane gets its own wrapping or clamping sum or difference, rounded mean, minimum or maximum, or comparison mask. No carry or borrow ever crosses from one lane into the next. Bitwise operations act on the whole vector and take no notice of the lane size.

A pipeline front end presents operands, an opcode, a lane-size code and a signedness bit together with an input strobe. Exactly one cycle later the unit presents the registered result and an output strobe. If the opcode and lane size do not form a supported pair, the unit returns an all-zero result and raises a flag in the same cycle as that result.

Top module: `simd_int_alu`

## Requirements
- R1: `out_valid` is high in the cycle after every cycle with `in_valid` high and low otherwise. The result and the flag for an accepted input appear in that same next cycle.
- R2: Opcode 0 (wrapping add) and opcode 1 (wrapping subtract, a minus b) give each lane's sum or difference modulo 2^W. This holds for every lane size code: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Nothing carries across a lane boundary.
- R3: Opcode 2 (clamping add) and opcode 3 (clamping subtract) give the exact lane result clamped to the lane's range. With `sgn` = 1 the lane is two's complement; with `sgn` = 0 it is unsigned. Sizes 8, 16 and 32 are supported.
- R4: Opcode 4 (carry out) is supported only at 32-bit unsigned lanes. It returns the carry of a + b in bit 0 of each lane and zeros in the upper 31 bits.
- R5: Opcode 5 (mean) returns (a + b + 1) / 2, rounded toward minus infinity. It is computed without overflow, signed or unsigned per `sgn`, at sizes 8, 16 and 32.
- R6: Opcode 6 returns the lane minimum and opcode 7 the lane maximum. The comparison is signed or unsigned per `sgn`, at sizes 8, 16 and 32.
- R7: Opcode 8 (a greater than b, signed per `sgn`) and opcode 9 (a equal to b) write all ones into a lane where the test holds and all zeros where it fails. Sizes 8, 16 and 32 are supported.
- R8: Opcodes 10 (AND), 11 (OR), 12 (XOR), 13 (NOT a, AND b) and 14 (NOR) act on all 128 bits, whatever the values of `esize` and `sgn`.
- R9: Several cases are unsupported: opcode 15, any lane-wise opcode other than 0 and 1 at size 64, and opcode 4 at any size other than 32 or with `sgn` = 1. For these the unit returns an all-zero result with `illegal` high. For supported cases `illegal` is low.
- R10: After reset `out_valid`, `result` and `illegal` are all zero.
- R11: `result` and `illegal` keep their last values in cycles that follow a cycle with `in_valid` low, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op | input | 4 | Operation code |
| esize | input | 2 | Lane size code: 8, 16, 32 or 64 bits |
| sgn | input | 1 | 1 selects two's complement lanes |
| a | input | 128 | First operand vector |
| b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result is presented this cycle |
| result | output | 128 | Registered lane results or mask |
| illegal | output | 1 | The accepted operation was unsupported |

## Verification
Every lane-wise test compares the whole 128-bit result against a scalar model. The model rebuilds each lane from wide integer arithmetic, so a carry that leaks across a lane boundary corrupts the neighbouring lane. That corruption shows in the very next output cycle. Because only one register stage exists, a lost or held strobe or a stale result register shows as a wrong `out_valid` or a wrong value in the cycle after the input. Clamping, rounding and sign-extension errors only show for operands near lane limits, so the directed cases aim at those limits at each size.

// File: rtl/simd_int_alu.sv
module simd_int_alu #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    esize,
  input  logic          sgn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          illegal
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADDS = 4'd2, OP_SUBS = 4'd3,
                         OP_CRY = 4'd4, OP_AVG = 4'd5, OP_MIN = 4'd6, OP_MAX = 4'd7,
                         OP_GT = 4'd8, OP_EQ = 4'd9, OP_AND = 4'd10, OP_OR = 4'd11,
                         OP_XOR = 4'd12, OP_ANDN = 4'd13, OP_NOR = 4'd14;

  logic [DW-1:0] size_res [4];
  logic [DW-1:0] bit_res, nxt;
  logic          legal, is_bitop;

  for (genvar g = 0; g < 4; g++) begin : g_size
    localparam int W = 8 << g;
    logic [DW-1:0] v;
    for (genvar l = 0; l < DW / W; l++) begin : g_lane
      logic [W-1:0] ea, eb, r, sat_add, sat_sub;
      logic [W:0]   sa, sb, s1, d1;
      logic         gt;
      assign ea = a[l*W +: W];
      assign eb = b[l*W +: W];
      assign sa = {sgn & ea[W-1], ea};
      assign sb = {sgn & eb[W-1], eb};
      assign s1 = sa + sb;
      assign d1 = sa - sb;
      assign gt = $signed(sa) > $signed(sb);
      assign sat_add = sgn ? ((s1[W] ^ s1[W-1]) ? {s1[W], {(W-1){~s1[W]}}} : s1[W-1:0])
                           : (s1[W] ? {W{1'b1}} : s1[W-1:0]);
      assign sat_sub = sgn ? ((d1[W] ^ d1[W-1]) ? {d1[W], {(W-1){~d1[W]}}} : d1[W-1:0])
                           : (d1[W] ? {W{1'b0}} : d1[W-1:0]);
      always_comb begin
        case (op)
          OP_ADD:  r = s1[W-1:0];
          OP_SUB:  r = d1[W-1:0];
          OP_ADDS: r = sat_add;
          OP_SUBS: r = sat_sub;
          OP_CRY:  r = {{(W-1){1'b0}}, s1[W]};
          OP_AVG:  r = s1[W:1] + {{(W-1){1'b0}}, s1[0]};
          OP_MIN:  r = gt ? eb : ea;
          OP_MAX:  r = gt ? ea : eb;
          OP_GT:   r = {W{gt}};
          OP_EQ:   r = {W{ea == eb}};
          default: r = '0;
        endcase
      end
      assign v[l*W +: W] = r;
    end
    assign size_res[g] = v;
  end

  always_comb begin
    is_bitop = 1'b1;
    case (op)
      OP_AND:  bit_res = a & b;
      OP_OR:   bit_res = a | b;
      OP_XOR:  bit_res = a ^ b;
      OP_ANDN: bit_res = ~a & b;
      OP_NOR:  bit_res = ~(a | b);
      default: begin bit_res = '0; is_bitop = 1'b0; end
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: legal = 1'b1;
      OP_CRY:         legal = (esize == 2'd2) && !sgn;
      OP_ADDS, OP_SUBS, OP_AVG, OP_MIN, OP_MAX, OP_GT, OP_EQ: legal = (esize != 2'd3);
      default:        legal = is_bitop;
    endcase
  end

  assign nxt = !legal ? '0 : (is_bitop ? bit_res : size_res[esize]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt;
        illegal <= !legal;
      end
    end
  end
endmodule

module simd_int_alu_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [1:0]    esize,
  input logic          sgn,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          illegal
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_zero_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));
  a_r9_op15_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd15) |=> illegal);
  a_r7_equal_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd9 && esize != 2'd3 && a == b) |=> (result == {DW{1'b1}}));
  a_r4_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4) |=> ((result & {(DW/32){32'hFFFF_FFFE}}) == '0));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

bind simd_int_alu simd_int_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_simd_int_alu.sv
module sim_simd_int_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   esize = '0;
  logic         sgn = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic         out_valid, illegal;
  logic [127:0] result;
  int total = 0, failed = 0;

  always #10 clk = ~clk;

  simd_int_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
                   .sgn(sgn), .a(a), .b(b), .out_valid(out_valid), .result(result),
                   .illegal(illegal));

  function automatic logic supported(input logic [3:0] o, input logic [1:0] s, input logic sg);
    if (o <= 4'd1) return 1'b1;
    if (o == 4'd4) return (s == 2'd2) && !sg;
    if (o <= 4'd9) return s != 2'd3;
    return o != 4'd15;
  endfunction

  function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] s, input logic sg,
                                         input logic [127:0] x, input logic [127:0] y);
    logic [127:0] r;
    logic signed [67:0] p, q, z, lo, hi;
    int w;
    r = '0;
    if (!supported(o, s, sg)) return r;
    case (o)
      4'd10: return x & y;
      4'd11: return x | y;
      4'd12: return x ^ y;
      4'd13: return ~x & y;
      4'd14: return ~(x | y);
      default: ;
    endcase
    w = 8 << s;
    lo = sg ? -(68'sd1 <<< (w - 1)) : 68'sd0;
    hi = sg ? (68'sd1 <<< (w - 1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
    for (int l = 0; l < 128 / w; l++) begin
      p = '0; q = '0;
      for (int k = 0; k < w; k++) begin p[k] = x[l*w+k]; q[k] = y[l*w+k]; end
      if (sg) for (int k = w; k < 68; k++) begin p[k] = p[w-1]; q[k] = q[w-1]; end
      case (o)
        4'd0: z = p + q;
        4'd1: z = p - q;
        4'd2: begin z = p + q; if (z > hi) z = hi; if (z < lo) z = lo; end
        4'd3: begin z = p - q; if (z > hi) z = hi; if (z < lo) z = lo; end
        4'd4: z = ((p + q) > hi) ? 68'sd1 : 68'sd0;
        4'd5: z = (p + q + 68'sd1) >>> 1;
        4'd6: z = (p < q) ? p : q;
        4'd7: z = (p > q) ? p : q;
        4'd8: z = (p > q) ? -68'sd1 : 68'sd0;
        default: z = (p == q) ? -68'sd1 : 68'sd0;
      endcase
      for (int k = 0; k < w; k++) r[l*w+k] = z[k];
    end
    return r;
  endfunction

  task automatic note(input string req, input logic ok, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] o, input logic [1:0] s, input logic sg,
                     input logic [127:0] x, input logic [127:0] y);
    logic [127:0] e;
    e = model(o, s, sg, x, y);
    @(negedge clk);
    op = o; esize = s; sgn = sg; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    note(req, out_valid === 1'b1 && result === e && illegal === !supported(o, s, sg),
         result, e);
  endtask

  task automatic t_reset;
    note("R10", out_valid === 1'b0 && illegal === 1'b0 && result === '0,
         {126'b0, out_valid, illegal} | result, '0);
  endtask

  task automatic t_wrap;
    for (int s = 0; s < 4; s++) begin
      run("R2", 4'd0, 2'(s), 1'b0, {128{1'b1}}, {16{8'h01}});
      run("R2", 4'd1, 2'(s), 1'b1, '0, {16{8'h01}});
      run("R2", 4'd0, 2'(s), 1'b0, {8{16'h8000}}, {8{16'h8001}});
    end
  endtask

  task automatic t_sat;
    for (int s = 0; s < 3; s++) begin
      run("R3", 4'd2, 2'(s), 1'b0, {16{8'hF0}}, {16{8'h20}});
      run("R3", 4'd2, 2'(s), 1'b1, {16{8'h70}}, {16{8'h20}});
      run("R3", 4'd2, 2'(s), 1'b1, {16{8'h90}}, {16{8'hA0}});
      run("R3", 4'd3, 2'(s), 1'b0, {16{8'h10}}, {16{8'h20}});
      run("R3", 4'd3, 2'(s), 1'b1, {16{8'h80}}, {16{8'h01}});
      run("R3", 4'd3, 2'(s), 1'b1, {16{8'h7F}}, {16{8'hFF}});
    end
  endtask

  task automatic t_carry;
    run("R4", 4'd4, 2'd2, 1'b0, {32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF},
        {32'h1, 32'h8000_0000, 32'h1, 32'h8000_0000});
  endtask

  task automatic t_avg;
    for (int s = 0; s < 3; s++) begin
      run("R5", 4'd5, 2'(s), 1'b0, {128{1'b1}}, {128{1'b1}});
      run("R5", 4'd5, 2'(s), 1'b1, {16{8'h80}}, {16{8'hFF}});
      run("R5", 4'd5, 2'(s), 1'b1, {16{8'h03}}, {16{8'hFC}});
    end
  endtask

  task automatic t_minmax;
    for (int s = 0; s < 3; s++)
      for (int sg = 0; sg < 2; sg++) begin
        run("R6", 4'd6, 2'(s), 1'(sg), {16{8'h85}}, {16{8'h05}});
        run("R6", 4'd7, 2'(s), 1'(sg), {16{8'h85}}, {16{8'h05}});
      end
  endtask

  task automatic t_cmp;
    for (int s = 0; s < 3; s++) begin
      run("R7", 4'd8, 2'(s), 1'b0, {8{16'h8001}}, {8{16'h0102}});
      run("R7", 4'd8, 2'(s), 1'b1, {8{16'h8001}}, {8{16'h0102}});
      run("R7", 4'd9, 2'(s), 1'b0, {64'h1234, 64'h5678}, {64'h1234, 64'h5679});
    end
  endtask

  task automatic t_bitops;
    for (int o = 10; o < 15; o++)
      run("R8", 4'(o), 2'(o % 4), 1'(o % 2), 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555,
          128'hFF00_FF00_0F0F_F0F0_1111_2222_3333_4444);
  endtask

  task automatic t_illegal;
    run("R9", 4'd15, 2'd0, 1'b0, {128{1'b1}}, {128{1'b1}});
    run("R9", 4'd2, 2'd3, 1'b0, {128{1'b1}}, {128{1'b1}});
    run("R9", 4'd4, 2'd1, 1'b0, {128{1'b1}}, {128{1'b1}});
    run("R9", 4'd4, 2'd2, 1'b1, {128{1'b1}}, {128{1'b1}});
  endtask

  task automatic t_hold;
    logic [127:0] e;
    run("R1", 4'd0, 2'd0, 1'b0, {16{8'h11}}, {16{8'h22}});
    e = {16{8'h33}};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op = 4'd15; a = $urandom; b = $urandom;
      note("R1", out_valid === 1'b0, {127'b0, out_valid}, '0);
      note("R11", result === e && illegal === 1'b0, result, e);
    end
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 200; i++)
      run("R2", 4'($urandom % 10), 2'($urandom % 4), 1'($urandom % 2),
          {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wrap(); t_sat(); t_carry(); t_avg(); t_minmax();
    t_cmp(); t_bitops(); t_illegal(); t_hold(); t_mixed();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule